// File: doc/BRIEF.md
# Excitation Synchronization Countdown Timer

This block holds back the start of excitation-signal generation and ADC triggering by a programmable number of sync-clock ticks. It runs in the core (sync) clock domain. Software places an 8-bit start count in the control word and then raises the enable bit. Each tick counts the value down. When a tick finds the count already at zero, the block emits a single-cycle trigger pulse for the ADC and the excitation generator. The block then waits until it is armed again.

Clearing the enable bit before expiry stops the countdown. The remaining count stays where it was. The live count is carried into the bus clock domain by a toggle request/acknowledge snapshot, so a status register can read it. The crossing keeps the whole 8-bit value stable while it is in flight. Each bus-side update lands 2 to 3 bus-clock cycles after the core side launches it.

Top module: `exc_sync_timer`

## Requirements
- R1: After reset, `trig_out` is 0 and `stat_count` reads 0.
- R2: When bit 15 of `ctrl_word` goes from 0 to 1, sampled on the core clock, the count loads bits 23:16 of `ctrl_word`. All other control bits have no effect on the count.
- R3: While armed, enabled and above zero, the count drops by exactly one on each core cycle where `tick` is 1. Cycles without `tick` leave it unchanged.
- R4: While armed and enabled, a tick that finds the count at 0 makes `trig_out` high for exactly one core cycle, starting the cycle after that tick's clock edge. A start count of N therefore fires on tick N+1, and a start count of 0 fires on the first tick.
- R5: After firing, the block is idle with the count at 0. Further ticks give no trigger, even with the enable bit held high, until bit 15 makes a fresh 0-to-1 transition.
- R6: Clearing bit 15 before expiry freezes the count at its last value. While bit 15 is low, ticks change nothing and no trigger is produced.
- R7: A new 0-to-1 transition of bit 15 after a freeze reloads the start count from bits 23:16. The frozen value is not resumed.
- R8: `stat_count` carries the core count into the bus domain as whole snapshots and never shows a value that is partly old and partly new. Once the core count is steady, `stat_count` equals it within 16 bus cycles.
- R9: If the enable rising edge and a tick fall in the same core cycle, the load wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core (sync) clock |
| rst_core | input | 1 | Synchronous active-high reset, core domain |
| ctrl_word | input | 32 | Control word: bits 23:16 start count, bit 15 enable |
| tick | input | 1 | Decrement strobe, one per sync tick |
| trig_out | output | 1 | One-cycle expiry pulse for ADC and excitation start |
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| stat_count | output | 8 | Remaining count as seen in the bus domain |

## Verification
Directed runs cover these cases:
- Start counts of 0 and 3, which separate an off-by-one in the expiry point from a correct "fire on tick N+1".
- A countdown broken by clearing enable and then followed by ticks, which tells freezing apart from a decrement that keeps running or a spurious trigger.
- A re-arm after the freeze, which tells a fresh load apart from a resume.
- An enable edge coinciding with a tick, which exposes a wrong priority between load and decrement.

Long random sequences then mix these patterns. They toggle the enable rarely, pick small start counts, fill the unused control bits with noise and vary the tick density. Every cycle's trigger is compared against a bench model. At intervals the bus-side readback is compared with the modelled count after the crossing has settled.

// File: rtl/exc_sync_pkg.sv
`timescale 1ns/1ps
package exc_sync_pkg;
  parameter int CTRL_W_DEF      = 32;
  parameter int CNT_W_DEF       = 8;
  parameter int START_LSB_DEF   = 16;
  parameter int EN_BIT_DEF      = 15;
  parameter int SYNC_STAGES_DEF = 2;

  typedef enum logic {
    CD_IDLE  = 1'b0,
    CD_ARMED = 1'b1
  } cd_state_t;
endpackage

// File: rtl/xsync_bit.sv
`timescale 1ns/1ps
module xsync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) ff[0] <= 1'b0;
        else     ff[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) ff[i] <= 1'b0;
        else     ff[i] <= ff[i-1];
      end
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/xsync_countdown.sv
`timescale 1ns/1ps
module xsync_countdown
  import exc_sync_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] start,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trig_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  cd_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             arm;

  assign arm = en && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CD_IDLE;
      cnt    <= ZERO;
      en_q   <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      en_q   <= en;
      trig_o <= 1'b0;
      if (arm) begin
        cnt   <= start;
        state <= CD_ARMED;
      end else if (state == CD_ARMED) begin
        if (!en) begin
          state <= CD_IDLE;
        end else if (tick) begin
          if (cnt == ZERO) begin
            trig_o <= 1'b1;
            state  <= CD_IDLE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/xsync_snap_tx.sv
`timescale 1ns/1ps
module xsync_snap_tx #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         ack_tgl,
  output logic         req_tgl,
  output logic [W-1:0] hold
);
  logic ack_seen;

  xsync_bit #(.STAGES(STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_tgl),
    .q   (ack_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl <= 1'b0;
      hold    <= '0;
    end else if (req_tgl == ack_seen) begin
      hold    <= din;
      req_tgl <= ~req_tgl;
    end
  end
endmodule

// File: rtl/xsync_snap_rx.sv
`timescale 1ns/1ps
module xsync_snap_rx #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_tgl,
  input  logic [W-1:0] hold,
  output logic         ack_tgl,
  output logic [W-1:0] dout
);
  logic req_seen;
  logic req_done;

  xsync_bit #(.STAGES(STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tgl),
    .q   (req_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_done <= 1'b0;
      dout     <= '0;
    end else if (req_seen != req_done) begin
      dout     <= hold;
      req_done <= req_seen;
    end
  end

  assign ack_tgl = req_done;
endmodule

// File: rtl/exc_sync_timer.sv
`timescale 1ns/1ps
module exc_sync_timer
  import exc_sync_pkg::*;
#(
  parameter int CTRL_W      = CTRL_W_DEF,
  parameter int CNT_W       = CNT_W_DEF,
  parameter int START_LSB   = START_LSB_DEF,
  parameter int EN_BIT      = EN_BIT_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_core,
  input  logic              rst_core,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              tick,
  output logic              trig_out,
  input  logic              clk_bus,
  input  logic              rst_bus,
  output logic [CNT_W-1:0]  stat_count
);
  logic [CNT_W-1:0] cnt_core;
  logic [CNT_W-1:0] hold_x;
  logic             req_x;
  logic             ack_x;
  logic             unused_ctrl;

  assign unused_ctrl = ^ctrl_word;

  xsync_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk    (clk_core),
    .rst    (rst_core),
    .en     (ctrl_word[EN_BIT]),
    .start  (ctrl_word[START_LSB +: CNT_W]),
    .tick   (tick),
    .cnt_o  (cnt_core),
    .trig_o (trig_out)
  );

  xsync_snap_tx #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_tx (
    .clk     (clk_core),
    .rst     (rst_core),
    .din     (cnt_core),
    .ack_tgl (ack_x),
    .req_tgl (req_x),
    .hold    (hold_x)
  );

  xsync_snap_rx #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk_bus),
    .rst     (rst_bus),
    .req_tgl (req_x),
    .hold    (hold_x),
    .ack_tgl (ack_x),
    .dout    (stat_count)
  );
endmodule

// File: rtl/exc_sync_timer_chk.sv
`timescale 1ns/1ps
module exc_sync_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_core,
  input logic             rst_core,
  input logic             clk_bus,
  input logic             rst_bus,
  input logic             en,
  input logic             trig_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold,
  input logic             req,
  input logic [CNT_W-1:0] stat
);
  AST_TRIG_SINGLE: assert property (@(posedge clk_core) disable iff (rst_core)
    trig_out |=> !trig_out); // R4
  AST_TRIG_AT_ZERO: assert property (@(posedge clk_core) disable iff (rst_core)
    trig_out |-> (cnt == '0)); // R4
  AST_FREEZE_OFF: assert property (@(posedge clk_core) disable iff (rst_core)
    !en |=> $stable(cnt)); // R6
  AST_NO_TRIG_OFF: assert property (@(posedge clk_core) disable iff (rst_core)
    !en |=> !trig_out); // R6
  AST_HOLD_WITH_REQ: assert property (@(posedge clk_core) disable iff (rst_core)
    !$stable(hold) |-> !$stable(req)); // R8
  AST_STAT_UNTORN: assert property (@(posedge clk_bus) disable iff (rst_bus)
    !$stable(stat) |-> (stat == hold)); // R8
endmodule

bind exc_sync_timer exc_sync_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_core (clk_core),
  .rst_core (rst_core),
  .clk_bus  (clk_bus),
  .rst_bus  (rst_bus),
  .en       (ctrl_word[EN_BIT]),
  .trig_out (trig_out),
  .cnt      (cnt_core),
  .hold     (hold_x),
  .req      (req_x),
  .stat     (stat_count)
);

// File: tb/sim_exc_sync_timer.sv
`timescale 1ns/1ps
module sim_exc_sync_timer;
  logic        clk_core = 1'b0;
  logic        clk_bus  = 1'b0;
  logic        rst_core = 1'b1;
  logic        rst_bus  = 1'b1;
  logic [31:0] ctrl     = '0;
  logic        tk       = 1'b0;
  logic        trig_out;
  logic [7:0]  stat_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  bit       m_en_prev = 1'b0;
  bit       m_armed   = 1'b0;
  bit [7:0] m_cnt     = '0;
  bit       m_fire    = 1'b0;

  always #5 clk_core = ~clk_core;  // core clock, 100 MHz
  always #4 clk_bus  = ~clk_bus;   // bus clock, 125 MHz

  exc_sync_timer u0 (
    .clk_core   (clk_core),
    .rst_core   (rst_core),
    .ctrl_word  (ctrl),
    .tick       (tk),
    .trig_out   (trig_out),
    .clk_bus    (clk_bus),
    .rst_bus    (rst_bus),
    .stat_count (stat_count)
  );

  function automatic logic [31:0] mk(input bit en, input bit [7:0] start, input bit [31:0] noise);
    logic [31:0] w;
    w = noise;
    w[23:16] = start;
    w[15] = en;
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input logic [31:0] c, input bit t);
    bit en;
    en = c[15];
    m_fire = 1'b0;
    if (en && !m_en_prev) begin
      m_cnt = c[23:16];
      m_armed = 1'b1;
    end else if (m_armed) begin
      if (!en) m_armed = 1'b0;
      else if (t) begin
        if (m_cnt == 0) begin
          m_fire = 1'b1;
          m_armed = 1'b0;
        end else m_cnt = m_cnt - 1;
      end
    end
    m_en_prev = en;
  endtask

  // one core cycle: drive at negedge, update model at the edge, check trigger next negedge
  task automatic step(input logic [31:0] c, input bit t, input string req);
    ctrl = c;
    tk   = t;
    @(posedge clk_core);
    model(c, t);
    @(negedge clk_core);
    check(req, int'(trig_out), int'(m_fire));
  endtask

  task automatic settle(input string req);
    tk = 1'b0;
    repeat (20) @(negedge clk_bus);
    check(req, int'(stat_count), int'(m_cnt));
    @(negedge clk_core);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk_core);
    rst_core = 1'b0;
    rst_bus  = 1'b0;
    @(negedge clk_core);
    check("R1", int'(trig_out), 0);
    repeat (20) @(negedge clk_bus);
    check("R1", int'(stat_count), 0);
    @(negedge clk_core);

    // R2/R3/R4: start 3, fires on the fourth tick
    step(mk(1'b1, 8'd3, 32'h0), 1'b0, "R2");
    settle("R2");
    step(mk(1'b1, 8'd3, 32'h0), 1'b1, "R3");
    step(mk(1'b1, 8'd3, 32'h0), 1'b0, "R3");
    step(mk(1'b1, 8'd3, 32'h0), 1'b1, "R3");
    settle("R3");
    step(mk(1'b1, 8'd3, 32'h0), 1'b1, "R4");
    check("R4", int'(trig_out), 0);
    step(mk(1'b1, 8'd3, 32'h0), 1'b1, "R4");
    check("R4", int'(trig_out), 1);
    // R5: enable still high, more ticks, no trigger, count 0
    for (int i = 0; i < 5; i++) step(mk(1'b1, 8'd3, 32'h0), 1'b1, "R5");
    settle("R5");

    // R4: start count 0 fires on the first tick
    step(mk(1'b0, 8'd0, 32'h0), 1'b0, "R4");
    step(mk(1'b1, 8'd0, 32'h0), 1'b0, "R4");
    step(mk(1'b1, 8'd0, 32'h0), 1'b1, "R4");
    check("R4", int'(trig_out), 1);

    // R6: freeze at 6 after four ticks from 10
    step(mk(1'b0, 8'd10, 32'h0), 1'b0, "R6");
    step(mk(1'b1, 8'd10, 32'h0), 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(mk(1'b1, 8'd10, 32'h0), 1'b1, "R6");
    for (int i = 0; i < 6; i++) step(mk(1'b0, 8'd10, 32'h0), 1'b1, "R6");
    settle("R6");
    check("R6", int'(stat_count), 6);

    // R7: re-arm reloads the start count
    step(mk(1'b1, 8'd9, 32'h0), 1'b0, "R7");
    settle("R7");
    check("R7", int'(stat_count), 9);

    // R9: enable rise and tick together
    step(mk(1'b0, 8'd5, 32'h0), 1'b0, "R9");
    step(mk(1'b1, 8'd5, 32'h0), 1'b1, "R9");
    settle("R9");
    check("R9", int'(stat_count), 5);

    // R2: noise in unused control bits does not disturb the load
    step(mk(1'b0, 8'd0, 32'h0), 1'b0, "R2");
    step(mk(1'b1, 8'd200, 32'hFF00_7FFF), 1'b0, "R2");
    settle("R2");
    check("R2", int'(stat_count), 200);

    // random mix
    begin
      bit       en_r;
      bit [7:0] st_r;
      en_r = 1'b0;
      st_r = 8'd4;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 24) == 0) begin
          en_r = ~en_r;
          st_r = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 12);
        end
        step(mk(en_r, 8'($urandom), 32'($urandom)) & ~32'h00FF_8000 | mk(en_r, st_r, 32'h0),
             bit'($urandom % 3 != 0), "R4");
        if ((i % 250) == 249) settle("R8");
      end
      settle("R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule